// File: doc/BRIEF.md
# SD Command Issue Unit

This unit starts SD card commands from a programmed command word and argument and returns the card's answer through four 32-bit response words. A command begins only when a command-register write carries its start flag. The unit then places an index and an argument on a simple request/response handshake toward the card-side logic. It sorts the returned bytes into the response words and reports either success or a missing response as a one-cycle event to the interrupt status logic.

The unit also sends the stop command (index 12) on its own when a data transfer has run out. It checks for this once after every launched command and once after every 32-bit FIFO data access that arrives while it is idle. It does this without altering the programmed command word or argument. A command flagged as a clock change never reaches the card but is still reported as complete. A counter ends any handshake that stays unanswered for too long.

Top module: `sd_cmd_unit`

## Requirements
- R1: A write to the command register while idle stores the word. It starts a command only if bit 31 is set. The stored word always reads back with bit 31 at 0. After reset, every output is zero.
- R2: A launched command (not a clock change) raises `card_req_valid` in the cycle after the write. `card_req_index` equals command bits 5:0 and `card_req_arg` equals the argument register. All three stay steady until the card answers or the wait expires.
- R3: A launched word with bit 21 set produces no request. `evt_cmd_done` is high for one cycle, in the cycle after the write.
- R4: If bit 6 is clear, any card answer counts as success (`evt_cmd_done`). The response words are left unchanged.
- R5: If bit 6 is set and bit 7 is clear, a 4-byte answer succeeds. Response word 0 becomes card bytes 0..3, with byte 0 in bits 31:24. Words 1..3 become zero. Card byte k sits at `card_rsp_data[127-8k -: 8]`. Word i of `resp_words` is at bits `[32i +: 32]`.
- R6: If bits 6 and 7 are both set, a 16-byte answer succeeds. Word 0 takes bytes 12..15, word 1 takes bytes 8..11, word 2 takes bytes 4..7 and word 3 takes bytes 0..3, each big-endian.
- R7: A card failure flag, or an answer length that does not match the requested type, raises `evt_no_resp` instead of `evt_cmd_done`. The response words are left unchanged. The two events are never high together.
- R8: If the card never answers, `card_req_valid` stays high for exactly `TIMEOUT_CYCLES` cycles. `evt_no_resp` then rises in the next cycle.
- R9: After a command resolves, if bit 12 is set and `xfer_remaining` is zero, a request with index 12 and argument 0 follows. Its outcome raises `evt_cmd_done` or `evt_no_resp` together with `evt_autostop_done`. The command word and argument keep their programmed values.
- R10: A `fifo_access` pulse while idle starts the same stop sequence, but only if bit 12 is set and `xfer_remaining` is zero. Otherwise no request follows.
- R11: While `busy` is high, command writes, argument writes and FIFO pulses are ignored. `card_req_valid` is high only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command word being written |
| arg_wr | input | 1 | Argument register write strobe |
| arg_wdata | input | 32 | Argument being written |
| fifo_access | input | 1 | One 32-bit FIFO data access took place |
| xfer_remaining | input | 32 | Bytes still left in the data transfer |
| card_rsp_valid | input | 1 | Card side answers the pending request |
| card_rsp_len | input | 5 | Answer length in bytes |
| card_rsp_data | input | 128 | Answer bytes, byte 0 in the top bits |
| card_rsp_fail | input | 1 | Card side reports failure |
| cmd_word | output | 32 | Stored command word |
| cmd_arg | output | 32 | Stored argument |
| resp_words | output | 128 | Four response words, word i at [32i +: 32] |
| card_req_valid | output | 1 | Request pending toward the card |
| card_req_index | output | 6 | Requested command index |
| card_req_arg | output | 32 | Requested argument |
| busy | output | 1 | A command or stop sequence is in progress |
| evt_cmd_done | output | 1 | One-cycle command-complete event |
| evt_no_resp | output | 1 | One-cycle missing-response event |
| evt_autostop_done | output | 1 | One-cycle automatic-stop-finished event |

## Verification
A request is visible one cycle after the launching write. A clock-change completion is also due in that cycle. Result events and response words follow one cycle after the cycle in which the card answer is presented. An automatic stop request appears two cycles after the answer that triggered it, or one cycle after a FIFO pulse. The timeout event follows exactly `TIMEOUT_CYCLES` request cycles. The bench drives and samples on the falling edge, so each value is read exactly one register stage after the stimulus that caused it. Where an action must not happen, the bench watches the request output for several cycles before the next stimulus.

// File: rtl/sd_cmd_pkg.sv
// Shared constants and types for the SD command issue unit.
// Assumes a 32-bit command word whose flag positions are fixed below.
package sd_cmd_pkg;
    localparam int CMD_W        = 32;
    localparam int IDX_W        = 6;
    localparam int START_BIT    = 31;
    localparam int CLKCHG_BIT   = 21;
    localparam int AUTOSTOP_BIT = 12;
    localparam int LONG_BIT     = 7;
    localparam int EXPECT_BIT   = 6;
    localparam int STOP_INDEX   = 12;
    localparam int SHORT_BYTES  = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_CHECK = 2'd2
    } seq_state_t;
endpackage

// File: rtl/sd_cmd_timeout.sv
// Response wait limiter: counts cycles while a request is pending.
// It signals expiry in the LIMIT-th pending cycle.
// Assumes LIMIT >= 2. The count clears whenever run is low.
module sd_cmd_timeout #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT);

    logic [CNT_W-1:0] cnt_q;

    // Counts pending cycles and restarts when no request is pending.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_W'(LIMIT - 1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expiry flag for the final allowed pending cycle.
    always_comb begin
        expired = run && (cnt_q == CNT_W'(LIMIT - 1));
    end
endmodule

// File: rtl/sd_cmd_resp_decode.sv
// Response classifier and word arranger.
// It decides whether a card answer satisfies the requested response type
// and builds the response words. Purely combinational.
// Assumes byte 0 of the answer sits in the top byte of data.
module sd_cmd_resp_decode
    import sd_cmd_pkg::*;
#(
    parameter int RESP_BYTES = 16,
    parameter int LEN_W      = 5
) (
    input  logic                    expect_rsp,
    input  logic                    long_rsp,
    input  logic                    fail,
    input  logic [LEN_W-1:0]        len,
    input  logic [8*RESP_BYTES-1:0] data,
    output logic                    ok,
    output logic                    load,
    output logic [8*RESP_BYTES-1:0] words
);
    localparam int WORDS = RESP_BYTES / 4;
    localparam int TOP   = 8 * RESP_BYTES - 1;

    logic [8*RESP_BYTES-1:0] long_words;
    logic [8*RESP_BYTES-1:0] short_words;

    // Arranges words: word i takes bytes 4*(WORDS-1-i)..+3, big-endian.
    generate
        for (genvar i = 0; i < WORDS; i++) begin : g_word
            assign long_words[32*i +: 32] = data[32*i +: 32];
            if (i == 0) begin : g_first
                assign short_words[31:0] = data[TOP -: 32];
            end else begin : g_rest
                assign short_words[32*i +: 32] = '0;
            end
        end
    endgenerate

    // Checks the answer length against the requested response type.
    always_comb begin
        if (fail) begin
            ok = 1'b0;
        end else if (!expect_rsp) begin
            ok = 1'b1;
        end else if (long_rsp) begin
            ok = (len == LEN_W'(RESP_BYTES));
        end else begin
            ok = (len == LEN_W'(SHORT_BYTES));
        end
        load  = ok && expect_rsp;
        words = long_rsp ? long_words : short_words;
    end
endmodule

// File: rtl/sd_cmd_seq.sv
// Command sequencer: launches requests, resolves answers or timeouts,
// and inserts the automatic stop command. It emits one-cycle events.
// Assumes launch is only asserted while busy is low.
module sd_cmd_seq
    import sd_cmd_pkg::*;
#(
    parameter int ARG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             launch_clkchg,
    input  logic [IDX_W-1:0] launch_idx,
    input  logic [ARG_W-1:0] arg_val,
    input  logic             stored_clkchg,
    input  logic             stored_auto,
    input  logic             xfer_zero,
    input  logic             fifo_access,
    input  logic             rsp_valid,
    input  logic             dec_ok,
    input  logic             dec_load,
    input  logic             tmo_expired,
    output logic             busy,
    output logic             wait_run,
    output logic             req_valid,
    output logic [IDX_W-1:0] req_index,
    output logic [ARG_W-1:0] req_arg,
    output logic             resp_load,
    output logic             evt_done,
    output logic             evt_noresp,
    output logic             evt_asdone
);
    seq_state_t       state_q;
    logic             is_stop_q;
    logic [IDX_W-1:0] idx_q;
    logic [ARG_W-1:0] arg_q;
    logic             resolve;
    logic             stop_due;

    // Decides when the pending request ends and whether a stop is due.
    always_comb begin
        resolve  = (state_q == ST_WAIT) && (rsp_valid || tmo_expired);
        stop_due = stored_auto && xfer_zero;
    end

    // Main sequence: idle, waiting for the card, post-command stop check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            is_stop_q  <= 1'b0;
            idx_q      <= '0;
            arg_q      <= '0;
            evt_done   <= 1'b0;
            evt_noresp <= 1'b0;
            evt_asdone <= 1'b0;
        end else begin
            evt_done   <= 1'b0;
            evt_noresp <= 1'b0;
            evt_asdone <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (launch) begin
                        is_stop_q <= 1'b0;
                        if (launch_clkchg) begin
                            evt_done <= 1'b1;
                            state_q  <= ST_CHECK;
                        end else begin
                            idx_q   <= launch_idx;
                            arg_q   <= arg_val;
                            state_q <= ST_WAIT;
                        end
                    end else if (fifo_access && stop_due) begin
                        is_stop_q <= 1'b1;
                        if (stored_clkchg) begin
                            evt_done   <= 1'b1;
                            evt_asdone <= 1'b1;
                        end else begin
                            idx_q   <= IDX_W'(STOP_INDEX);
                            arg_q   <= '0;
                            state_q <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (resolve) begin
                        if (rsp_valid && dec_ok) begin
                            evt_done <= 1'b1;
                        end else begin
                            evt_noresp <= 1'b1;
                        end
                        if (is_stop_q) begin
                            evt_asdone <= 1'b1;
                            state_q    <= ST_IDLE;
                        end else begin
                            state_q <= ST_CHECK;
                        end
                    end
                end
                ST_CHECK: begin
                    if (stop_due) begin
                        is_stop_q <= 1'b1;
                        if (stored_clkchg) begin
                            evt_done   <= 1'b1;
                            evt_asdone <= 1'b1;
                            state_q    <= ST_IDLE;
                        end else begin
                            idx_q   <= IDX_W'(STOP_INDEX);
                            arg_q   <= '0;
                            state_q <= ST_WAIT;
                        end
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drives the handshake outputs and the response load strobe.
    always_comb begin
        busy      = (state_q != ST_IDLE);
        wait_run  = (state_q == ST_WAIT);
        req_valid = wait_run;
        req_index = idx_q;
        req_arg   = arg_q;
        resp_load = wait_run && rsp_valid && dec_load;
    end
endmodule

// File: rtl/sd_cmd_unit.sv
// SD command issue unit top: holds the command, argument and response
// registers, and wires the sequencer, decoder and wait limiter together.
// Assumes register writes arrive as single-cycle strobes.
module sd_cmd_unit
    import sd_cmd_pkg::*;
#(
    parameter int ARG_W          = 32,
    parameter int RESP_BYTES     = 16,
    parameter int LEN_W          = 5,
    parameter int XFER_W         = 32,
    parameter int TIMEOUT_CYCLES = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_wr,
    input  logic [CMD_W-1:0]        cmd_wdata,
    input  logic                    arg_wr,
    input  logic [ARG_W-1:0]        arg_wdata,
    input  logic                    fifo_access,
    input  logic [XFER_W-1:0]       xfer_remaining,
    input  logic                    card_rsp_valid,
    input  logic [LEN_W-1:0]        card_rsp_len,
    input  logic [8*RESP_BYTES-1:0] card_rsp_data,
    input  logic                    card_rsp_fail,
    output logic [CMD_W-1:0]        cmd_word,
    output logic [ARG_W-1:0]        cmd_arg,
    output logic [8*RESP_BYTES-1:0] resp_words,
    output logic                    card_req_valid,
    output logic [IDX_W-1:0]        card_req_index,
    output logic [ARG_W-1:0]        card_req_arg,
    output logic                    busy,
    output logic                    evt_cmd_done,
    output logic                    evt_no_resp,
    output logic                    evt_autostop_done
);
    logic [CMD_W-1:0]        cmd_q;
    logic [ARG_W-1:0]        arg_q;
    logic [8*RESP_BYTES-1:0] resp_q;
    logic                    launch;
    logic                    xfer_zero;
    logic                    wait_run;
    logic                    tmo_expired;
    logic                    dec_ok;
    logic                    dec_load;
    logic [8*RESP_BYTES-1:0] dec_words;
    logic                    resp_load;

    // Qualifies a launch and the zero-remaining condition.
    always_comb begin
        launch    = cmd_wr && cmd_wdata[START_BIT] && !busy;
        xfer_zero = (xfer_remaining == '0);
    end

    // Command and argument registers; the start flag is never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
            arg_q <= '0;
        end else begin
            if (cmd_wr && !busy) begin
                cmd_q <= cmd_wdata & ~(CMD_W'(1) << START_BIT);
            end
            if (arg_wr && !busy) begin
                arg_q <= arg_wdata;
            end
        end
    end

    // Response registers, loaded only on an accepted answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else if (resp_load) begin
            resp_q <= dec_words;
        end
    end

    sd_cmd_seq #(
        .ARG_W (ARG_W)
    ) i_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .launch        (launch),
        .launch_clkchg (cmd_wdata[CLKCHG_BIT]),
        .launch_idx    (cmd_wdata[IDX_W-1:0]),
        .arg_val       (arg_q),
        .stored_clkchg (cmd_q[CLKCHG_BIT]),
        .stored_auto   (cmd_q[AUTOSTOP_BIT]),
        .xfer_zero     (xfer_zero),
        .fifo_access   (fifo_access),
        .rsp_valid     (card_rsp_valid),
        .dec_ok        (dec_ok),
        .dec_load      (dec_load),
        .tmo_expired   (tmo_expired),
        .busy          (busy),
        .wait_run      (wait_run),
        .req_valid     (card_req_valid),
        .req_index     (card_req_index),
        .req_arg       (card_req_arg),
        .resp_load     (resp_load),
        .evt_done      (evt_cmd_done),
        .evt_noresp    (evt_no_resp),
        .evt_asdone    (evt_autostop_done)
    );

    sd_cmd_resp_decode #(
        .RESP_BYTES (RESP_BYTES),
        .LEN_W      (LEN_W)
    ) i_decode (
        .expect_rsp (cmd_q[EXPECT_BIT]),
        .long_rsp   (cmd_q[LONG_BIT]),
        .fail       (card_rsp_fail),
        .len        (card_rsp_len),
        .data       (card_rsp_data),
        .ok         (dec_ok),
        .load       (dec_load),
        .words      (dec_words)
    );

    sd_cmd_timeout #(
        .LIMIT (TIMEOUT_CYCLES)
    ) i_timeout (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (wait_run),
        .expired (tmo_expired)
    );

    // Output copies of the held registers.
    always_comb begin
        cmd_word   = cmd_q;
        cmd_arg    = arg_q;
        resp_words = resp_q;
    end
endmodule

// File: rtl/sd_cmd_unit_chk.sv
// Property checker for the SD command issue unit, bound to the top.
// Observes ports only.
module sd_cmd_unit_chk
    import sd_cmd_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_wr,
    input logic [CMD_W-1:0] cmd_wdata,
    input logic [CMD_W-1:0] cmd_word,
    input logic [31:0]      cmd_arg,
    input logic             card_req_valid,
    input logic [IDX_W-1:0] card_req_index,
    input logic [31:0]      card_req_arg,
    input logic             busy,
    input logic             evt_cmd_done,
    input logic             evt_no_resp,
    input logic             evt_autostop_done
);
    AST_LAUNCH_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && cmd_wdata[START_BIT] && !busy |=> busy); // R1
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        card_req_valid && $past(card_req_valid) |-> $stable(card_req_index) && $stable(card_req_arg)); // R2
    AST_CLKCHG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        card_req_valid |-> !cmd_word[CLKCHG_BIT]); // R3
    AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_cmd_done && evt_no_resp)); // R7
    AST_STOP_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        card_req_valid && (card_req_index != cmd_word[IDX_W-1:0]) |-> (card_req_index == IDX_W'(STOP_INDEX)) && (card_req_arg == '0)); // R9
    AST_STOP_RESOLVED: assert property (@(posedge clk) disable iff (!rst_n)
        evt_autostop_done |-> evt_cmd_done || evt_no_resp); // R9
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(cmd_word) && $stable(cmd_arg)); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !card_req_valid); // R11
endmodule

bind sd_cmd_unit sd_cmd_unit_chk i_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .cmd_wr            (cmd_wr),
    .cmd_wdata         (cmd_wdata),
    .cmd_word          (cmd_word),
    .cmd_arg           (cmd_arg),
    .card_req_valid    (card_req_valid),
    .card_req_index    (card_req_index),
    .card_req_arg      (card_req_arg),
    .busy              (busy),
    .evt_cmd_done      (evt_cmd_done),
    .evt_no_resp       (evt_no_resp),
    .evt_autostop_done (evt_autostop_done)
);

// File: tb/test_sd_cmd_unit.sv
module test_sd_cmd_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_wr = 1'b0;
    logic [31:0]  cmd_wdata = '0;
    logic         arg_wr = 1'b0;
    logic [31:0]  arg_wdata = '0;
    logic         fifo_access = 1'b0;
    logic [31:0]  xfer_remaining = 32'd1;
    logic         card_rsp_valid = 1'b0;
    logic [4:0]   card_rsp_len = '0;
    logic [127:0] card_rsp_data = '0;
    logic         card_rsp_fail = 1'b0;
    logic [31:0]  cmd_word;
    logic [31:0]  cmd_arg;
    logic [127:0] resp_words;
    logic         card_req_valid;
    logic [5:0]   card_req_index;
    logic [31:0]  card_req_arg;
    logic         busy;
    logic         evt_cmd_done;
    logic         evt_no_resp;
    logic         evt_autostop_done;

    int vectors = 0;
    int fails = 0;
    logic [5:0]  got_idx;
    logic [31:0] got_arg;
    logic        ev_done, ev_nr, ev_as, got_req;

    localparam logic [31:0] GO   = 32'h8000_0000;
    localparam logic [31:0] CLK  = 32'h0020_0000;
    localparam logic [31:0] AUTO = 32'h0000_1000;
    localparam logic [31:0] LONG = 32'h0000_0080;
    localparam logic [31:0] EXP  = 32'h0000_0040;
    localparam logic [127:0] LDATA = 128'h000102030405060708090A0B0C0D0E0F;

    sd_cmd_unit i_sd_cmd_unit (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .arg_wr(arg_wr), .arg_wdata(arg_wdata), .fifo_access(fifo_access),
        .xfer_remaining(xfer_remaining), .card_rsp_valid(card_rsp_valid),
        .card_rsp_len(card_rsp_len), .card_rsp_data(card_rsp_data),
        .card_rsp_fail(card_rsp_fail), .cmd_word(cmd_word), .cmd_arg(cmd_arg),
        .resp_words(resp_words), .card_req_valid(card_req_valid),
        .card_req_index(card_req_index), .card_req_arg(card_req_arg),
        .busy(busy), .evt_cmd_done(evt_cmd_done), .evt_no_resp(evt_no_resp),
        .evt_autostop_done(evt_autostop_done)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    task automatic wr_cmd(input logic [31:0] w);
        @(negedge clk); cmd_wr = 1'b1; cmd_wdata = w;
        @(negedge clk); cmd_wr = 1'b0;
    endtask

    task automatic wr_arg(input logic [31:0] a);
        @(negedge clk); arg_wr = 1'b1; arg_wdata = a;
        @(negedge clk); arg_wr = 1'b0;
    endtask

    // Waits for a request, answers it, then captures the result events.
    task automatic respond(input logic [4:0] len, input logic [127:0] data, input logic fl);
        int n = 0;
        while (!card_req_valid && n < 200) begin
            @(negedge clk); n++;
        end
        got_req = card_req_valid;
        got_idx = card_req_index;
        got_arg = card_req_arg;
        card_rsp_valid = 1'b1; card_rsp_len = len; card_rsp_data = data; card_rsp_fail = fl;
        @(negedge clk);
        card_rsp_valid = 1'b0; card_rsp_fail = 1'b0;
        ev_done = evt_cmd_done; ev_nr = evt_no_resp; ev_as = evt_autostop_done;
    endtask

    task automatic no_req(input int n, input string req);
        logic seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (card_req_valid) seen = 1'b1;
        end
        check(req, seen, 1'b0);
    endtask

    task automatic t_reset();
        check("R1 reset busy", busy, 0);
        check("R1 reset req", card_req_valid, 0);
        check("R1 reset resp", resp_words, 0);
        check("R1 reset cmd", cmd_word, 0);
        check("R1 reset events", {evt_cmd_done, evt_no_resp, evt_autostop_done}, 0);
    endtask

    task automatic t_store_only();
        wr_cmd(EXP | 32'd3);
        check("R1 store without start", cmd_word, EXP | 32'd3);
        check("R1 no launch busy", busy, 0);
        no_req(4, "R1 no request without start");
    endtask

    task automatic t_long();
        wr_arg(32'h0000_0100);
        wr_cmd(GO | LONG | EXP | 32'd2);
        check("R1 start flag reads zero", cmd_word[31], 0);
        respond(5'd16, LDATA, 1'b0);
        check("R2 index", got_idx, 6'd2);
        check("R2 argument", got_arg, 32'h0000_0100);
        check("R6 done event", {ev_done, ev_nr}, 2'b10);
        check("R6 long words", resp_words, LDATA);
    endtask

    task automatic t_short();
        wr_arg(32'h1234_5678);
        wr_cmd(GO | EXP | 32'd17);
        respond(5'd4, {32'hDEAD_BEEF, 96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF}, 1'b0);
        check("R2 short index", got_idx, 6'd17);
        check("R2 short argument", got_arg, 32'h1234_5678);
        check("R5 done event", {ev_done, ev_nr}, 2'b10);
        check("R5 short words", resp_words, {96'h0, 32'hDEAD_BEEF});
    endtask

    task automatic t_no_expect();
        wr_cmd(GO | 32'd8);
        respond(5'd0, LDATA, 1'b0);
        check("R4 done event", {ev_done, ev_nr}, 2'b10);
        check("R4 words unchanged", resp_words, {96'h0, 32'hDEAD_BEEF});
    endtask

    task automatic t_bad();
        wr_cmd(GO | LONG | EXP | 32'd9);
        respond(5'd4, LDATA, 1'b0);
        check("R7 length mismatch event", {ev_done, ev_nr}, 2'b01);
        check("R7 mismatch words unchanged", resp_words, {96'h0, 32'hDEAD_BEEF});
        wr_cmd(GO | EXP | 32'd13);
        respond(5'd4, LDATA, 1'b1);
        check("R7 failure event", {ev_done, ev_nr}, 2'b01);
        check("R7 failure words unchanged", resp_words, {96'h0, 32'hDEAD_BEEF});
    endtask

    task automatic t_clkchg();
        wr_cmd(GO | CLK | EXP | 32'd5);
        check("R3 immediate done", evt_cmd_done, 1);
        no_req(5, "R3 no request for clock change");
    endtask

    task automatic t_timeout();
        int n = 0;
        wr_cmd(GO | EXP | 32'd7);
        while (card_req_valid && n < 500) begin
            @(negedge clk); n++;
        end
        check("R8 request cycles", n, 64);
        check("R8 timeout event", {evt_cmd_done, evt_no_resp}, 2'b01);
    endtask

    task automatic t_autostop();
        xfer_remaining = 32'd0;
        wr_arg(32'hAAAA_5555);
        wr_cmd(GO | AUTO | EXP | 32'd18);
        respond(5'd4, {32'h0000_0900, 96'h0}, 1'b0);
        check("R9 first command", {got_idx, ev_as}, {6'd18, 1'b0});
        respond(5'd4, {32'h0000_0C00, 96'h0}, 1'b0);
        check("R9 stop requested", got_req, 1);
        check("R9 stop index", got_idx, 6'd12);
        check("R9 stop argument", got_arg, 32'd0);
        check("R9 stop events", {ev_done, ev_nr, ev_as}, 3'b101);
        check("R9 stop response", resp_words, {96'h0, 32'h0000_0C00});
        check("R9 command kept", cmd_word, AUTO | EXP | 32'd18);
        check("R9 argument kept", cmd_arg, 32'hAAAA_5555);
    endtask

    task automatic t_fifo();
        @(negedge clk); fifo_access = 1'b1;
        @(negedge clk); fifo_access = 1'b0;
        check("R10 fifo stop request", card_req_valid, 1);
        respond(5'd4, {32'h0000_0D00, 96'h0}, 1'b0);
        check("R10 fifo stop index", got_idx, 6'd12);
        check("R10 fifo stop done", ev_as, 1);
        xfer_remaining = 32'd5;
        @(negedge clk); fifo_access = 1'b1;
        @(negedge clk); fifo_access = 1'b0;
        no_req(4, "R10 no stop with data left");
        wr_cmd(GO | AUTO | EXP | 32'd19);
        respond(5'd4, {32'h0000_0E00, 96'h0}, 1'b0);
        check("R10 no stop event", ev_as, 0);
        no_req(5, "R10 no stop after command with data left");
    endtask

    task automatic t_busy();
        xfer_remaining = 32'd1;
        wr_arg(32'h0000_0055);
        wr_cmd(GO | EXP | 32'd20);
        check("R11 busy while pending", busy, 1);
        cmd_wr = 1'b1; cmd_wdata = GO | EXP | 32'd21;
        arg_wr = 1'b1; arg_wdata = 32'h0000_0099;
        @(negedge clk);
        cmd_wr = 1'b0; arg_wr = 1'b0;
        respond(5'd4, {32'h0000_0F00, 96'h0}, 1'b0);
        check("R11 index not replaced", got_idx, 6'd20);
        check("R11 command ignored", cmd_word, EXP | 32'd20);
        check("R11 argument ignored", cmd_arg, 32'h0000_0055);
        no_req(5, "R11 no second launch");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        vectors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_store_only();
        t_long();
        t_short();
        t_no_expect();
        t_bad();
        t_clkchg();
        t_timeout();
        t_autostop();
        t_fifo();
        t_busy();
        summary();
    end
endmodule